// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregator

This block gathers event interrupts from a set of ports and reduces them to one active-low interrupt pin. Each port has a transmit group and a receive group of status inputs. A detector watches every status bit and latches an event bit on a qualifying transition. Most bits react only to the inactive-to-active edge. Bits chosen by a per-group parameter mask react to both edges, so a lost-delineation style status raises one event when it is lost and a second when it is regained. Latched event bits stay set until software reads the register that holds them.

Masking is applied at three levels. Per-bit enables decide which latched transmit and receive events feed a port's summary register. That register also holds a latched one-second tick and a live external interrupt level. A summary enable selects which summary bits form the port's flag. The port flags make up a global port-summary register. A port enable mask and a global pin-enable bit then decide whether the flags reach the pin.

The pin is driven by a two-state machine. In `PIN_QUIET` the pin is high. The transition *raise* moves to `PIN_ACTIVE`, where the pin is low, when the pin enable is set and any enabled port flag is set. The transition *release* returns to `PIN_QUIET` when that condition clears. The pin therefore follows its sources one clock later.

Registers are reached over a simple strobe bus: `reg_rd` and `reg_wr`, with registered read data.

Address map:
- Port `p` occupies addresses `p*8 + off`, where `off` is:
  - 0: transmit events
  - 1: receive events
  - 2: transmit enables
  - 3: receive enables
  - 4: summary
  - 5: summary enables
- The global registers start at `NPORTS*8`:
  - +0: port summary
  - +1: port enables
  - +2: mode

Top module: `irq_aggregator`

## Requirements
- R1: An event bit not named in its group's dual mask sets only on a 0-to-1 change of its status bit. A 1-to-0 change leaves it clear.
- R2: An event bit named in its group's dual mask sets on both a rising and a falling change of its status bit. The default receive mask is 0x80, making receive bit 7 dual.
- R3: A read of a transmit event register (offset 0) or receive event register (offset 1) returns the latched bits on `reg_rdata` one clock after the strobe and clears them.
- R4: An event detected in the same clock as a read of its register remains set after that read.
- R5: Enable bit i at offset 2 (transmit) or 3 (receive) gates event bit i into the summary. A disabled event does not reach the summary or the pin, yet it stays latched.
- R6: The summary register (offset 4) holds the following, and a read of it clears bit 2:
  - bit 0: OR of the enabled transmit events
  - bit 1: OR of the enabled receive events
  - bit 2: a one-second tick, latched
  - bit 3: the live external interrupt level
- R7: The summary enable (offset 5, bits 3:0) masks each summary bit. The OR of the masked bits is port bit p of the port-summary register (global +0), which is read without the port mask applied.
- R8: `irq_n` is low one clock after mode bit 3 is set and some port-summary bit is set with its port enable (global +1, bit p) set. It returns high one clock after that condition ends.
- R9: While mode bit 3 (global +2) is clear, `irq_n` stays high whatever the sources.
- R10: After reset all event, enable, mode and read-data registers are zero and `irq_n` is high.
- R11: The enable registers and the mode register read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_status | input | NPORTS*EVW | Transmit status bits; port p uses slice p*EVW +: EVW |
| rx_status | input | NPORTS*EVW | Receive status bits, same slicing |
| onesec_tick | input | NPORTS | One-clock tick per port, latched into summary bit 2 |
| ext_irq | input | NPORTS | External interrupt level per port, summary bit 3 |
| reg_addr | input | AW | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; clears the addressed event bits |
| reg_wdata | input | EVW | Write data |
| reg_rdata | output | EVW | Read data, valid the clock after `reg_rd` |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
The bench builds the block with NPORTS=3 and EVW=8, keeping the default dual masks. With three ports, the global registers sit at a non-power-of-two port index (24 to 26). It also lets an event on the last port be traced through the port-summary register while an untouched middle port is confirmed to stay clear. Receive bit 7 exercises the dual-edge path, and transmit bits 0, 3 and 7 exercise the single-edge path.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int OFF_W       = 3;
    localparam int PORT_STRIDE = 1 << OFF_W;

    localparam logic [OFF_W-1:0] OFF_TX_EV  = 3'd0;
    localparam logic [OFF_W-1:0] OFF_RX_EV  = 3'd1;
    localparam logic [OFF_W-1:0] OFF_TX_EN  = 3'd2;
    localparam logic [OFF_W-1:0] OFF_RX_EN  = 3'd3;
    localparam logic [OFF_W-1:0] OFF_SUM    = 3'd4;
    localparam logic [OFF_W-1:0] OFF_SUM_EN = 3'd5;

    localparam logic [OFF_W-1:0] G_PORT_SUM = 3'd0;
    localparam logic [OFF_W-1:0] G_PORT_EN  = 3'd1;
    localparam logic [OFF_W-1:0] G_MODE     = 3'd2;

    localparam int MODE_PIN_EN_BIT = 3;

    localparam int SUM_W   = 4;
    localparam int SUM_TX  = 0;
    localparam int SUM_RX  = 1;
    localparam int SUM_SEC = 2;
    localparam int SUM_EXT = 3;

    typedef enum logic {
        PIN_QUIET  = 1'b0,
        PIN_ACTIVE = 1'b1
    } pin_state_e;

endpackage

// File: rtl/irq_event_group.sv
module irq_event_group #(
    parameter int             W         = 8,
    parameter logic [W-1:0]   DUAL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status,
    input  logic         rd_clr,
    output logic [W-1:0] ev_lat
);

    logic [W-1:0] prev_q;
    logic [W-1:0] evt;

    // Per-bit edge qualifier chosen by the dual mask
    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        if (DUAL_MASK[gi]) begin : g_dual
            assign evt[gi] = status[gi] ^ prev_q[gi];
        end else begin : g_single
            assign evt[gi] = status[gi] & ~prev_q[gi];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            ev_lat <= '0;
        end else begin
            prev_q <= status;
            // A new event wins over a clearing read in the same clock
            ev_lat <= (rd_clr ? '0 : ev_lat) | evt;
        end
    end

    // R4: every detected event is present after the edge, read or not
    a_r4_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((ev_lat & $past(evt)) == $past(evt)));

    // R3: after a read, only bits that saw a new event remain
    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> ((ev_lat & ~$past(evt)) == '0));

    // R1: no bit rises without a qualifying edge
    a_r1_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_lat & ~$past(ev_lat) & ~$past(evt)) == '0));

endmodule

// File: rtl/irq_port_level.sv
module irq_port_level
    import irq_agg_pkg::*;
#(
    parameter int           W       = 8,
    parameter logic [W-1:0] DUAL_TX = '0,
    parameter logic [W-1:0] DUAL_RX = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     tx_status,
    input  logic [W-1:0]     rx_status,
    input  logic             onesec_tick,
    input  logic             ext_irq,
    input  logic             hit,
    input  logic [OFF_W-1:0] off,
    input  logic             wr,
    input  logic             rd,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rd_val,
    output logic             port_flag
);

    logic [W-1:0]     tx_lat, rx_lat;
    logic [W-1:0]     tx_en_q, rx_en_q;
    logic [SUM_W-1:0] sum_en_q;
    logic [SUM_W-1:0] sum_raw;
    logic             sec_lat;

    logic rd_tx, rd_rx, rd_sum;
    logic wr_tx_en, wr_rx_en, wr_sum_en;

    assign rd_tx     = hit & rd & (off == OFF_TX_EV);
    assign rd_rx     = hit & rd & (off == OFF_RX_EV);
    assign rd_sum    = hit & rd & (off == OFF_SUM);
    assign wr_tx_en  = hit & wr & (off == OFF_TX_EN);
    assign wr_rx_en  = hit & wr & (off == OFF_RX_EN);
    assign wr_sum_en = hit & wr & (off == OFF_SUM_EN);

    irq_event_group #(.W(W), .DUAL_MASK(DUAL_TX)) u_tx_grp (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (tx_status),
        .rd_clr (rd_tx),
        .ev_lat (tx_lat)
    );

    irq_event_group #(.W(W), .DUAL_MASK(DUAL_RX)) u_rx_grp (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (rx_status),
        .rd_clr (rd_rx),
        .ev_lat (rx_lat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en_q  <= '0;
            rx_en_q  <= '0;
            sum_en_q <= '0;
            sec_lat  <= 1'b0;
        end else begin
            if (wr_tx_en)  tx_en_q  <= wdata;
            if (wr_rx_en)  rx_en_q  <= wdata;
            if (wr_sum_en) sum_en_q <= wdata[SUM_W-1:0];
            sec_lat <= (sec_lat & ~rd_sum) | onesec_tick;
        end
    end

    always_comb begin
        sum_raw          = '0;
        sum_raw[SUM_TX]  = |(tx_lat & tx_en_q);
        sum_raw[SUM_RX]  = |(rx_lat & rx_en_q);
        sum_raw[SUM_SEC] = sec_lat;
        sum_raw[SUM_EXT] = ext_irq;
    end

    assign port_flag = |(sum_raw & sum_en_q);

    always_comb begin
        unique case (off)
            OFF_TX_EV:  rd_val = tx_lat;
            OFF_RX_EV:  rd_val = rx_lat;
            OFF_TX_EN:  rd_val = tx_en_q;
            OFF_RX_EN:  rd_val = rx_en_q;
            OFF_SUM:    rd_val = W'(sum_raw);
            OFF_SUM_EN: rd_val = W'(sum_en_q);
            default:    rd_val = '0;
        endcase
    end

    // R6: a tick is visible in the summary on the next clock
    a_r6_tick_latched: assert property (@(posedge clk) disable iff (!rst_n)
        onesec_tick |=> sum_raw[SUM_SEC]);

    // R11: a written transmit enable holds the written value
    a_r11_tx_en_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx_en |=> (tx_en_q == $past(wdata)));

endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
    import irq_agg_pkg::*;
#(
    parameter int NP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] port_flags,
    input  logic [NP-1:0] port_en,
    input  logic          pin_en,
    output logic          irq_n
);

    pin_state_e state_q, state_d;
    logic       want;

    assign want = pin_en & (|(port_flags & port_en));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIN_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_QUIET:  if (want)  state_d = PIN_ACTIVE;   // raise
            PIN_ACTIVE: if (!want) state_d = PIN_QUIET;    // release
        endcase
    end

    always_comb begin
        unique case (state_q)
            PIN_QUIET:  irq_n = 1'b1;
            PIN_ACTIVE: irq_n = 1'b0;
        endcase
    end

    // R9: a cleared pin enable keeps the pin high
    a_r9_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_en |=> irq_n);

    // R8: an enabled flag pulls the pin low one clock later
    a_r8_pin_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_en && ((port_flags & port_en) != '0)) |=> !irq_n);

    // R8: with no enabled flag the pin releases one clock later
    a_r8_pin_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((port_flags & port_en) == '0) |=> irq_n);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int              NPORTS       = 4,
    parameter int              EVW          = 8,
    parameter logic [EVW-1:0]  DUAL_TX_MASK = 8'h00,
    parameter logic [EVW-1:0]  DUAL_RX_MASK = 8'h80,
    localparam int             AW           = $clog2((NPORTS + 1) * PORT_STRIDE)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORTS*EVW-1:0]   tx_status,
    input  logic [NPORTS*EVW-1:0]   rx_status,
    input  logic [NPORTS-1:0]       onesec_tick,
    input  logic [NPORTS-1:0]       ext_irq,
    input  logic [AW-1:0]           reg_addr,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [EVW-1:0]          reg_wdata,
    output logic [EVW-1:0]          reg_rdata,
    output logic                    irq_n
);

    localparam int IDX_W = AW - OFF_W;

    logic [IDX_W-1:0] addr_idx;
    logic [OFF_W-1:0] addr_off;
    logic             g_hit;

    logic [NPORTS-1:0] port_hit;
    logic [NPORTS-1:0] port_flags;
    logic [EVW-1:0]    port_rd [NPORTS];

    logic [NPORTS-1:0] port_en_q;
    logic [EVW-1:0]    mode_q;
    logic [EVW-1:0]    rd_mux;

    assign addr_idx = reg_addr[AW-1:OFF_W];
    assign addr_off = reg_addr[OFF_W-1:0];
    assign g_hit    = (addr_idx == IDX_W'(NPORTS));

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign port_hit[p] = (addr_idx == IDX_W'(p));

        irq_port_level #(
            .W       (EVW),
            .DUAL_TX (DUAL_TX_MASK),
            .DUAL_RX (DUAL_RX_MASK)
        ) u_port (
            .clk         (clk),
            .rst_n       (rst_n),
            .tx_status   (tx_status[p*EVW +: EVW]),
            .rx_status   (rx_status[p*EVW +: EVW]),
            .onesec_tick (onesec_tick[p]),
            .ext_irq     (ext_irq[p]),
            .hit         (port_hit[p]),
            .off         (addr_off),
            .wr          (reg_wr),
            .rd          (reg_rd),
            .wdata       (reg_wdata),
            .rd_val      (port_rd[p]),
            .port_flag   (port_flags[p])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_en_q <= '0;
            mode_q    <= '0;
        end else if (reg_wr && g_hit) begin
            if (addr_off == G_PORT_EN) port_en_q <= reg_wdata[NPORTS-1:0];
            if (addr_off == G_MODE)    mode_q    <= reg_wdata;
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (port_hit[p]) rd_mux = port_rd[p];
        end
        if (g_hit) begin
            unique case (addr_off)
                G_PORT_SUM: rd_mux = EVW'(port_flags);
                G_PORT_EN:  rd_mux = EVW'(port_en_q);
                G_MODE:     rd_mux = mode_q;
                default:    rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    irq_pin_ctrl #(.NP(NPORTS)) u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_flags (port_flags),
        .port_en    (port_en_q),
        .pin_en     (mode_q[MODE_PIN_EN_BIT]),
        .irq_n      (irq_n)
    );

    // R11: the mode register takes the written data
    a_r11_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && g_hit && addr_off == G_MODE) |=> (mode_q == $past(reg_wdata)));

    // R3: read data only moves after a read strobe
    a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NP  = 3;
    localparam int W   = 8;
    localparam int AW  = $clog2((NP + 1) * 8);
    localparam int GB  = NP * 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP*W-1:0]   tx_status = '0;
    logic [NP*W-1:0]   rx_status = '0;
    logic [NP-1:0]     onesec_tick = '0;
    logic [NP-1:0]     ext_irq = '0;
    logic [AW-1:0]     reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [W-1:0]      reg_wdata = '0;
    logic [W-1:0]      reg_rdata;
    logic              irq_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [W-1:0] exp_q[$];
    string        tag_q[$];
    logic         rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_aggregator #(.NPORTS(NP), .EVW(W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_status   (tx_status),
        .rx_status   (rx_status),
        .onesec_tick (onesec_tick),
        .ext_irq     (ext_irq),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq_n       (irq_n)
    );

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] pa(input int p, input int off);
        return AW'(p * 8 + off);
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Driver: issues a read and pushes the expected value
    task automatic rd(input logic [AW-1:0] a, input logic [W-1:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pin(input logic e, input string tag);
        chk(W'(irq_n), W'(e), tag);
    endtask

    // Monitor: compares read data the clock after each strobe
    always @(posedge clk) rd_seen <= reg_rd;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            chk(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R10 reset state
        pin(1'b1, "R10 pin after reset");
        chk(reg_rdata, 8'h00, "R10 rdata after reset");
        rd(pa(0, 0), 8'h00, "R10 tx events");
        rd(AW'(GB + 2), 8'h00, "R10 mode");
        rd(pa(0, 5), 8'h00, "R10 summary enable");

        wr(pa(0, 2), 8'hFF);
        wr(pa(0, 3), 8'hFF);
        wr(pa(0, 5), 8'h0F);
        wr(AW'(GB + 1), 8'h07);
        wr(AW'(GB + 2), 8'h08);
        rd(AW'(GB + 2), 8'h08, "R11 mode readback");
        rd(AW'(GB + 1), 8'h07, "R11 port enable readback");

        // R1 single-edge on transmit bit 7
        tx_status[7] = 1'b1;
        wait_cyc(2);
        pin(1'b0, "R8 pin on tx event");
        rd(pa(0, 0), 8'h80, "R3 tx event read");
        wait_cyc(1);
        pin(1'b1, "R3 pin after clear");
        rd(pa(0, 0), 8'h00, "R3 tx cleared");
        tx_status[7] = 1'b0;
        wait_cyc(2);
        rd(pa(0, 0), 8'h00, "R1 no set on fall");
        pin(1'b1, "R1 pin stays high");

        // R4 event in the read clock
        tx_status[0] = 1'b1;
        rd(pa(0, 0), 8'h00, "R4 read during event");
        rd(pa(0, 0), 8'h01, "R4 event kept");
        wait_cyc(1);
        pin(1'b1, "R4 pin after clear");
        tx_status[0] = 1'b0;
        wait_cyc(1);

        // R5 first-level mask
        wr(pa(0, 2), 8'hFE);
        tx_status[0] = 1'b1;
        wait_cyc(2);
        pin(1'b1, "R5 masked event hidden");
        rd(pa(0, 4), 8'h00, "R5 summary masked");
        rd(pa(0, 0), 8'h01, "R5 masked bit still latched");
        wr(pa(0, 2), 8'hFF);
        tx_status[0] = 1'b0;
        wait_cyc(1);
        pin(1'b1, "R5 pin after mask restore");

        // R2 dual-edge on receive bit 7
        rx_status[7] = 1'b1;
        wait_cyc(2);
        rd(pa(0, 1), 8'h80, "R2 rx rise");
        wait_cyc(1);
        pin(1'b1, "R2 pin after rise clear");
        rx_status[7] = 1'b0;
        wait_cyc(2);
        pin(1'b0, "R2 pin on fall");
        rd(pa(0, 1), 8'h80, "R2 rx fall");
        // receive bit 0 single-edge
        rx_status[0] = 1'b1;
        wait_cyc(1);
        rx_status[0] = 1'b0;
        wait_cyc(2);
        rd(pa(0, 1), 8'h01, "R1 rx single pulse");
        rd(pa(0, 1), 8'h00, "R1 rx once only");

        // R6 one-second tick and external level
        onesec_tick[0] = 1'b1;
        wait_cyc(1);
        onesec_tick[0] = 1'b0;
        rd(pa(0, 4), 8'h04, "R6 tick latched");
        rd(pa(0, 4), 8'h00, "R6 tick cleared");
        wait_cyc(1);
        pin(1'b1, "R6 pin after tick clear");
        ext_irq[0] = 1'b1;
        wait_cyc(2);
        pin(1'b0, "R8 pin on ext");
        rd(pa(0, 4), 8'h08, "R6 ext level");
        rd(AW'(GB), 8'h01, "R7 port summary bit 0");

        // R7 summary mask
        wr(pa(0, 5), 8'h07);
        wait_cyc(1);
        pin(1'b1, "R7 pin with ext masked");
        rd(AW'(GB), 8'h00, "R7 port summary masked");
        wr(pa(0, 5), 8'h0F);
        wait_cyc(1);
        pin(1'b0, "R7 pin unmasked");

        // R8 port mask
        wr(AW'(GB + 1), 8'h06);
        wait_cyc(1);
        pin(1'b1, "R8 pin with port masked");
        rd(AW'(GB), 8'h01, "R8 port summary ignores port mask");
        wr(AW'(GB + 1), 8'h07);
        wait_cyc(1);
        pin(1'b0, "R8 pin port unmasked");

        // R9 global pin enable
        wr(AW'(GB + 2), 8'h00);
        wait_cyc(1);
        pin(1'b1, "R9 pin disabled");
        rd(AW'(GB + 2), 8'h00, "R11 mode cleared");
        wr(AW'(GB + 2), 8'h08);
        wait_cyc(1);
        pin(1'b0, "R9 pin re-enabled");
        ext_irq[0] = 1'b0;
        wait_cyc(2);
        pin(1'b1, "R8 pin release");

        // Last port path
        wr(pa(2, 2), 8'hFF);
        wr(pa(2, 5), 8'h01);
        tx_status[2*W + 3] = 1'b1;
        wait_cyc(2);
        pin(1'b0, "R8 pin on port 2");
        rd(AW'(GB), 8'h04, "R7 port summary bit 2");
        rd(pa(2, 0), 8'h08, "R3 port 2 tx read");
        wait_cyc(1);
        pin(1'b1, "R3 pin after port 2 clear");
        rd(pa(1, 1), 8'h00, "R10 port 1 untouched");
        rd(pa(2, 2), 8'hFF, "R11 port 2 tx enable");
        wait_cyc(3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule